// File: doc/BRIEF.md
# CMI Line Encoder with Forced Violations

This block turns a non-return-to-zero transmit bit stream into Coded Mark Inversion line symbols. Each bit clock produces one 2-bit symbol whose upper bit is the first half-bit and whose lower bit is the second half-bit. A serializer running at twice the bit rate can shift these symbols onto the line, most significant bit first. Zero bits always carry a mid-bit transition. One bits are sent at a steady level, and that level alternates from one one-bit to the next.

For line testing, a request input forces code rule violations. Forced violations work on zero bits and on one bits alike. A request that stays high is honoured only for a limited number of consecutive bit clocks, five by default. After that the request has no effect until it has been low for at least one bit. Transmit data and the request are both captured on the falling edge of the bit clock, and the symbol register updates on the following rising edge.

Top module: `cmi_line_encoder`

## Requirements
- R1: Reset is synchronous and active high. It drives `line_sym` to 2'b01, clears the request run counter, and makes the first one-bit after reset go out as 2'b11.
- R2: `tx_data` and `viol_req` are captured on the falling edge of `clk`. A change after that falling edge has no effect on the symbol of that bit. The symbol appears on `line_sym` after the next rising edge.
- R3: A zero bit with no honoured request is sent as 2'b01: low for the first half, high for the second.
- R4: One bits with no honoured request alternate between 2'b11 and 2'b00. Zero bits in between do not disturb the alternation.
- R5: A zero bit with an honoured request is sent as 2'b10.
- R6: A one bit with an honoured request repeats the level of the previous one-bit (2'b11 or 2'b00) and leaves the alternation unchanged. The next normal one-bit takes the opposite level. Before any one-bit has been sent, the previous level counts as low.
- R7: A request held high on consecutive bits is honoured on the first LIMIT of them (default 5). From bit LIMIT+1 onward it is ignored, and those bits are coded normally.
- R8: A single bit with the request low re-arms the limiter, so the next high request is honoured again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; inputs captured on falling edge, symbol updated on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 1 | Transmit data bit |
| viol_req | input | 1 | Request to force a code rule violation on the current bit |
| line_sym | output | 2 | CMI symbol; bit 1 is the first half-bit, bit 0 the second |

## Verification
The encoder's normal alternation of one-bits and the forced violation can act on the same bit. A requested violation on a one-bit must hold the alternation, while the run limiter may at the same moment decide that the request is no longer honoured. The bench provokes this by holding the request high across a run of mixed ones and zeros longer than the limit. Its reference model predicts each symbol and the tracker level bit by bit, so a one-bit that falls on the sixth high cycle must come out as a normal alternated one and not as a repeat.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  typedef logic [1:0] cmi_sym_t;
  localparam cmi_sym_t SYM_ZERO     = 2'b01;
  localparam cmi_sym_t SYM_ZERO_BAD = 2'b10;
  localparam cmi_sym_t SYM_HIGH     = 2'b11;
  localparam cmi_sym_t SYM_LOW      = 2'b00;
endpackage

// File: rtl/cmi_fall_sampler.sv
module cmi_fall_sampler #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // capture on the falling edge so the rising-edge logic sees settled data
  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cmi_viol_limiter.sv
module cmi_viol_limiter #(
  parameter int LIMIT = 5,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic honour
);
  logic [CNT_W-1:0] run_q;

  // run_q counts earlier consecutive high requests, saturating at LIMIT
  assign honour = req && (run_q < CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst)                        run_q <= '0;
    else if (!req)                  run_q <= '0;
    else if (run_q < CNT_W'(LIMIT)) run_q <= run_q + 1'b1;
  end

  p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
    run_q <= CNT_W'(LIMIT));
  p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
    !req |=> run_q == '0);
  p_saturated_r7: assert property (@(posedge clk) disable iff (rst)
    (req && run_q == CNT_W'(LIMIT)) |=> !honour || !req);
endmodule

// File: rtl/cmi_symbol_mapper.sv
module cmi_symbol_mapper
  import cmi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_d,
  input  logic     force_bad,
  output cmi_sym_t sym_q
);
  logic next_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q     <= SYM_ZERO;
      next_high <= 1'b1;
    end else if (!bit_d) begin
      sym_q <= force_bad ? SYM_ZERO_BAD : SYM_ZERO;
    end else if (!force_bad) begin
      sym_q     <= next_high ? SYM_HIGH : SYM_LOW;
      next_high <= !next_high;
    end else begin
      // repeat the level of the previous one-bit, tracker held
      sym_q <= next_high ? SYM_LOW : SYM_HIGH;
    end
  end

  p_zero_normal_r3: assert property (@(posedge clk) disable iff (rst)
    (!bit_d && !force_bad) |=> sym_q == SYM_ZERO);
  p_zero_bad_r5: assert property (@(posedge clk) disable iff (rst)
    (!bit_d && force_bad) |=> sym_q == SYM_ZERO_BAD);
  p_one_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_d && !force_bad) |=> (sym_q[1] == sym_q[0]) && (next_high != $past(next_high)));
  p_one_bad_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_d && force_bad) |=> $stable(next_high) && (sym_q[1] == sym_q[0]));
  p_zero_keeps_track_r4: assert property (@(posedge clk) disable iff (rst)
    !bit_d |=> $stable(next_high));
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
  import cmi_pkg::*;
#(
  parameter int LIMIT = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_data,
  input  logic       viol_req,
  output logic [1:0] line_sym
);
  logic [1:0] cap;
  logic       honour;
  cmi_sym_t   sym;

  cmi_fall_sampler #(.W(2)) u_fall (
    .clk (clk),
    .rst (rst),
    .d   ({tx_data, viol_req}),
    .q   (cap)
  );

  cmi_viol_limiter #(.LIMIT(LIMIT)) u_lim (
    .clk    (clk),
    .rst    (rst),
    .req    (cap[0]),
    .honour (honour)
  );

  cmi_symbol_mapper u_map (
    .clk       (clk),
    .rst       (rst),
    .bit_d     (cap[1]),
    .force_bad (honour),
    .sym_q     (sym)
  );

  assign line_sym = sym;

  p_reset_sym_r1: assert property (@(posedge clk)
    rst |=> line_sym == SYM_ZERO);
endmodule

// File: tb/test_cmi_line_encoder.sv
module test_cmi_line_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_data = 1'b0;
  logic       viol_req = 1'b0;
  logic [1:0] line_sym;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  // reference model state
  int m_run = 0;
  bit m_next_high = 1'b1;

  int          q_cyc[$];
  logic [1:0]  q_sym[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  cmi_line_encoder i_cmi_line_encoder (
    .clk      (clk),
    .rst      (rst),
    .tx_data  (tx_data),
    .viol_req (viol_req),
    .line_sym (line_sym)
  );

  function automatic logic [1:0] model(input bit d, input bit v);
    bit eff;
    logic [1:0] e;
    eff = v && (m_run < 5);
    if (!v) m_run = 0;
    else if (m_run < 5) m_run = m_run + 1;
    if (!d) e = eff ? 2'b10 : 2'b01;
    else if (!eff) begin
      e = m_next_high ? 2'b11 : 2'b00;
      m_next_high = !m_next_high;
    end else e = m_next_high ? 2'b00 : 2'b11;
    return e;
  endfunction

  task automatic push(input bit d, input bit v, input string tag);
    q_cyc.push_back(cyc);
    q_sym.push_back(model(d, v));
    q_tag.push_back(tag);
  endtask

  // driver: one bit per clock; optional flip of inputs after the falling edge
  task automatic send(input bit d, input bit v, input string tag, input bit glitch = 0);
    @(posedge clk); #1;
    tx_data = d; viol_req = v;
    push(d, v, tag);
    if (glitch) begin
      @(negedge clk); #1;
      tx_data = !d; viol_req = !v;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; tx_data = 1'b0; viol_req = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    n_tests++;
    if (line_sym !== 2'b01) begin
      n_fail++;
      $display("FAIL R1 reset symbol: got %b expected 01", line_sym);
    end
    m_run = 0; m_next_high = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    push(1'b0, 1'b0, "R1");
  endtask

  // monitor: compare each expected symbol one rising edge after its driving cycle
  always @(posedge clk) begin
    cyc++;
    #2;
    while (q_cyc.size() > 0 && q_cyc[0] == cyc - 1) begin
      n_tests++;
      if (line_sym !== q_sym[0]) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: got %b expected %b", q_tag[0], cyc, line_sym, q_sym[0]);
      end
      void'(q_cyc.pop_front()); void'(q_sym.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: first one after reset is high-high
    send(1, 0, "R1");
    // R3: plain zeros
    for (int i = 0; i < 3; i++) send(0, 0, "R3");
    // R4: alternation across mixed data
    send(1, 0, "R4"); send(1, 0, "R4"); send(0, 0, "R4");
    send(1, 0, "R4"); send(0, 0, "R4"); send(0, 0, "R4"); send(1, 0, "R4");
    // R5: forced violation on zero
    send(0, 1, "R5"); send(0, 0, "R5");
    // R6: forced violation on one holds the tracker
    send(1, 0, "R6"); send(1, 1, "R6"); send(1, 0, "R6"); send(1, 1, "R6"); send(1, 0, "R6");
    // R7: held request across eight bits, ones fall on and after the cutoff
    send(0, 0, "R7");
    send(1, 1, "R7"); send(0, 1, "R7"); send(1, 1, "R7"); send(0, 1, "R7");
    send(1, 1, "R7"); send(1, 1, "R7"); send(0, 1, "R7"); send(1, 1, "R7");
    // R8: one low bit re-arms
    send(1, 0, "R8"); send(0, 1, "R8"); send(1, 1, "R8"); send(0, 0, "R8");
    // R7: exactly at the limit with zeros only
    for (int i = 0; i < 7; i++) send(0, 1, "R7");
    send(0, 0, "R8"); send(0, 1, "R8");
    // R2: inputs flipped after the falling edge must not matter
    send(1, 0, "R2", 1); send(0, 1, "R2", 1); send(1, 1, "R2", 1); send(0, 0, "R2", 1);
    send(1, 0, "R2");
    // R1: reset mid-stream restores tracker and counter
    send(1, 1, "R1"); send(0, 1, "R1"); send(0, 1, "R1");
    do_reset();
    send(1, 0, "R1"); send(1, 0, "R1");
    send(0, 1, "R1");
    send(0, 0, "R3"); send(0, 0, "R3");
    @(posedge clk); @(posedge clk); #4;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule